// File: doc/BRIEF.md
# Sixteen-bit four-register processor core

A compact multi-cycle processor core with a separate instruction port and data port. Each instruction word is 16 bits wide and takes two clock cycles: one to fetch it and one to execute it. Halt is the only exception, since after its execute cycle the core stops. There are two formats. A register format carries a destination and two sources for arithmetic and logic operations. A displacement format names a target register and a base register, and carries an 8-bit signed offset used by loads, stores, address generation and branches. State is held in four 16-bit general registers and a 16-bit program counter.

Both ports assume a simple synchronous memory. The memory samples the address and read strobe at the falling clock edge, and the data it returns is captured on the next rising edge. The core therefore has no wait states and no handshake. Any decoding of memory-mapped peripherals is done outside the core. A write-back flag marks every cycle in which a general register is written. A halt flag rises once a halt instruction has executed and stays high until reset. The asynchronous reset input is released through an internal synchronizer, so execution starts two rising edges after the reset input goes high.

Top module: `cpu16_core`

## Requirements
- R1: While the reset input is low, and for the two rising edges after it goes high, the core drives a fetch of address 0 with the data strobes, write-back flag and halt flag low. Reset clears the program counter and all four registers to zero.
- R2: Each instruction other than halt takes exactly two cycles. In the fetch cycle the instruction read strobe is high and the instruction address equals the program counter. The instruction word is captured at the end of that cycle. In the following execute cycle the instruction read strobe is low.
- R3: Bits [15:12] hold the opcode. Bit 15 low selects the register format, with first source in [11:10], second source in [9:8] and destination in [7:6]. Opcode 0 writes the 16-bit wrapping sum, 1 the bitwise AND, and 2 the first source minus the second.
- R4: Opcode 3 writes 1 when the first source is less than the second as signed 16-bit values, and 0 otherwise. Opcode 4 writes the complement of the first source. Opcode 6 writes the first source shifted right by one with a zero fill.
- R5: In the displacement format, [11:10] is the target, [9:8] the base and [7:0] a two's-complement offset. The effective address is the base plus the sign-extended offset. Opcode 8 raises the data read strobe in its execute cycle with the data address equal to the effective address, and writes the returned word to the target.
- R6: Opcode 9 raises the data write strobe in its execute cycle, with the data address equal to the effective address and the write data equal to the target register.
- R7: Opcode A writes the effective address into the target register. This includes offsets of -128 and +127.
- R8: Opcode E branches to the effective address when the target register is zero, and otherwise goes on to the next word. It writes no register.
- R9: Opcode D jumps to the effective address. Opcode F writes the address of the next word into the target and jumps to the effective address. When the target and the base are the same register, the address is computed from the base value before the write.
- R10: Opcodes 5, B and C change no register and no memory, and the program counter advances by one.
- R11: Opcode 7 stops the core. From the cycle after its execute cycle the halt flag is high and stays high, and no instruction or data strobe is raised until reset.
- R12: The write-back flag is high in exactly those execute cycles that write a general register (opcodes 0, 1, 2, 3, 4, 6, 8, A and F), and low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; memory is sampled by the environment on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_addr | output | 16 | Word address of the instruction being fetched |
| instr_rd | output | 1 | Instruction read strobe, high in fetch cycles |
| instr_data | input | 16 | Instruction word, captured at the end of the fetch cycle |
| data_addr | output | 16 | Effective address for loads and stores |
| data_rd | output | 1 | Data read strobe, high in a load's execute cycle |
| data_wr | output | 1 | Data write strobe, high in a store's execute cycle |
| data_wdata | output | 16 | Store data |
| data_rdata | input | 16 | Load data, captured at the end of the load's execute cycle |
| wb_flag | output | 1 | High in cycles that write a general register |
| halt_flag | output | 1 | High once a halt instruction has executed |

## Verification
The assertions assume the environment behaves as a zero-wait memory. A word requested by a strobe is present on the data inputs before the next rising edge, and the reset input changes only away from the rising edge. The stimulus keeps to this by modelling both memories on the falling edge and by moving the reset input only at falling edges. The program drives every opcode. It includes a taken and a not-taken conditional branch, a link whose target is also its base, offsets at both ends of the signed range, and an address sum that wraps. A second run after a mid-session reset checks that the registers start from zero again.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

  localparam int WORD_W = 16;
  localparam int NREG   = 4;
  localparam int RIDX_W = $clog2(NREG);
  localparam int DISP_W = 8;

  typedef enum logic [3:0] {
    OP_ADD   = 4'h0,
    OP_AND   = 4'h1,
    OP_SUB   = 4'h2,
    OP_SLT   = 4'h3,
    OP_NOT   = 4'h4,
    OP_EXR   = 4'h5,
    OP_SHR   = 4'h6,
    OP_HLT   = 4'h7,
    OP_LD    = 4'h8,
    OP_ST    = 4'h9,
    OP_LDA   = 4'hA,
    OP_RSV_B = 4'hB,
    OP_RSV_C = 4'hC,
    OP_JMP   = 4'hD,
    OP_BZ    = 4'hE,
    OP_BAL   = 4'hF
  } opcode_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_HALT  = 2'd2
  } phase_e;

  // Instruction word split; low holds the destination in [7:6] or the offset.
  typedef struct packed {
    opcode_e             op;
    logic [RIDX_W-1:0]   fa;
    logic [RIDX_W-1:0]   fb;
    logic [DISP_W-1:0]   low;
  } instr_t;

endpackage

// File: rtl/cpu16_rst_sync.sv
module cpu16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain[STAGES-1];

endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int NREG = 4,
  parameter int W    = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [NREG*W-1:0] bank_flat;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic         hit;
    logic [W-1:0] q;
    assign hit = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wdata;
    end
    assign bank_flat[g*W +: W] = q;
  end

  assign rdata_a = bank_flat[raddr_a*W +: W];
  assign rdata_b = bank_flat[raddr_b*W +: W];

  // A written word is visible in the bank on the following cycle.
  assert_write_lands_R12: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (bank_flat[$past(waddr)*W +: W] == $past(wdata)));

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  opcode_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_AND:  y = a & b;
      OP_SUB:  y = a - b;
      OP_SLT:  y = ($signed(a) < $signed(b)) ? W'(1) : '0;
      OP_NOT:  y = ~a;
      OP_SHR:  y = {1'b0, a[W-1:1]};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [WORD_W-1:0] instr_addr,
  output logic              instr_rd,
  input  logic [WORD_W-1:0] instr_data,
  output logic [WORD_W-1:0] data_addr,
  output logic              data_rd,
  output logic              data_wr,
  output logic [WORD_W-1:0] data_wdata,
  input  logic [WORD_W-1:0] data_rdata,
  output logic              wb_flag,
  output logic              halt_flag
);

  localparam int EXT_W = WORD_W - DISP_W;

  logic              rst_core_n;
  phase_e            state, state_nx;
  logic [WORD_W-1:0] pc, pc_nx, pc_inc;
  logic              pc_en, ir_en;
  logic [WORD_W-1:0] ir;
  instr_t            fld;
  logic [WORD_W-1:0] ra_val, rb_val, ea, alu_y;
  logic              we;
  logic [RIDX_W-1:0] waddr;
  logic [WORD_W-1:0] wdata;
  logic              rd_q, wr_q;

  cpu16_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign fld    = ir;
  assign pc_inc = pc + WORD_W'(1);
  assign ea     = rb_val + {{EXT_W{fld.low[DISP_W-1]}}, fld.low};

  cpu16_regfile #(.NREG(NREG), .W(WORD_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .we      (we),
    .waddr   (waddr),
    .wdata   (wdata),
    .raddr_a (fld.fa),
    .raddr_b (fld.fb),
    .rdata_a (ra_val),
    .rdata_b (rb_val)
  );

  cpu16_alu #(.W(WORD_W)) u_alu (
    .op (fld.op),
    .a  (ra_val),
    .b  (rb_val),
    .y  (alu_y)
  );

  // Next-state and datapath control
  always_comb begin
    state_nx = state;
    pc_nx    = pc;
    pc_en    = 1'b0;
    ir_en    = 1'b0;
    we       = 1'b0;
    waddr    = fld.low[DISP_W-1 -: RIDX_W];
    wdata    = alu_y;
    rd_q     = 1'b0;
    wr_q     = 1'b0;
    unique case (state)
      ST_FETCH: begin
        ir_en    = 1'b1;
        state_nx = ST_EXEC;
      end
      ST_EXEC: begin
        state_nx = ST_FETCH;
        pc_en    = 1'b1;
        pc_nx    = pc_inc;
        unique case (fld.op)
          OP_ADD, OP_AND, OP_SUB, OP_SLT, OP_NOT, OP_SHR: we = 1'b1;
          OP_EXR, OP_RSV_B, OP_RSV_C: ;
          OP_HLT: begin
            state_nx = ST_HALT;
            pc_en    = 1'b0;
          end
          OP_LD: begin
            rd_q  = 1'b1;
            we    = 1'b1;
            waddr = fld.fa;
            wdata = data_rdata;
          end
          OP_ST: wr_q = 1'b1;
          OP_LDA: begin
            we    = 1'b1;
            waddr = fld.fa;
            wdata = ea;
          end
          OP_JMP: pc_nx = ea;
          OP_BZ:  if (ra_val == '0) pc_nx = ea;
          OP_BAL: begin
            we    = 1'b1;
            waddr = fld.fa;
            wdata = pc_inc;
            pc_nx = ea;
          end
          default: ;
        endcase
      end
      ST_HALT: ;
      default: state_nx = ST_FETCH;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state <= ST_FETCH;
      pc    <= '0;
      ir    <= '0;
    end else begin
      state <= state_nx;
      if (pc_en) pc <= pc_nx;
      if (ir_en) ir <= instr_data;
    end
  end

  assign instr_addr = pc;
  assign instr_rd   = (state == ST_FETCH);
  assign data_addr  = ea;
  assign data_rd    = rd_q;
  assign data_wr    = wr_q;
  assign data_wdata = ra_val;
  assign wb_flag    = we;
  assign halt_flag  = (state == ST_HALT);

  assert_fetch_then_exec_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    instr_rd |=> !instr_rd);

  assert_pc_held_in_fetch_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state == ST_FETCH) |=> $stable(pc));

  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(data_rd && data_wr));

  assert_data_after_fetch_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (data_rd || data_wr) |-> $past(instr_rd));

  assert_nop_advances_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state == ST_EXEC && (fld.op == OP_EXR || fld.op == OP_RSV_B || fld.op == OP_RSV_C))
      |=> (pc == $past(pc) + WORD_W'(1)) && !$past(wb_flag));

  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    halt_flag |=> halt_flag);

  assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    halt_flag |-> !instr_rd && !data_rd && !data_wr && !wb_flag);

  assert_wb_only_exec_R12: assert property (@(posedge clk) disable iff (!rst_core_n)
    wb_flag |-> $past(instr_rd));

endmodule

// File: tb/cpu16_core_test.sv
`timescale 1ns/1ps
module cpu16_core_test;

  logic        clk;
  logic        rst_n;
  logic [15:0] instr_addr, data_addr, data_wdata;
  logic [15:0] instr_data, data_rdata;
  logic        instr_rd, data_rd, data_wr, wb_flag, halt_flag;

  cpu16_core uut (
    .clk(clk), .rst_n(rst_n),
    .instr_addr(instr_addr), .instr_rd(instr_rd), .instr_data(instr_data),
    .data_addr(data_addr), .data_rd(data_rd), .data_wr(data_wr),
    .data_wdata(data_wdata), .data_rdata(data_rdata),
    .wb_flag(wb_flag), .halt_flag(halt_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] imem [64];
  logic [15:0] dmem [256];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Behavioural reference state
  logic [15:0] m_pc, m_ir;
  logic [15:0] m_r [4];
  int          m_phase;
  int          m_hold;
  string       m_tag;

  function automatic logic [15:0] enc_r(int op, int a, int b, int d);
    return {op[3:0], a[1:0], b[1:0], d[1:0], 6'd0};
  endfunction

  function automatic logic [15:0] enc_d(int op, int t, int base, int disp);
    return {op[3:0], t[1:0], base[1:0], disp[7:0]};
  endfunction

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'h0, 4'h1, 4'h2:         return "R3";
      4'h3, 4'h4, 4'h6:         return "R4";
      4'h8:                     return "R5";
      4'h9:                     return "R6";
      4'hA:                     return "R7";
      4'hE:                     return "R8";
      4'hD, 4'hF:               return "R9";
      4'h7:                     return "R11";
      default:                  return "R10";
    endcase
  endfunction

  function automatic logic [15:0] m_ea();
    return m_r[m_ir[9:8]] + {{8{m_ir[7]}}, m_ir[7:0]};
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [3:0]  op;
    logic [15:0] a, b, nxt;
    if (!rst_n) begin
      m_pc = 0; m_phase = 0; m_hold = 0; m_ir = 0; m_tag = "R1";
      for (int i = 0; i < 4; i++) m_r[i] = 16'h0;
    end else if (m_hold < 2) begin
      m_hold++;
    end else if (m_phase == 0) begin
      m_ir = imem[m_pc[5:0]];
      m_phase = 1;
    end else if (m_phase == 1) begin
      op = m_ir[15:12]; a = m_r[m_ir[11:10]]; b = m_r[m_ir[9:8]];
      nxt = m_pc + 16'd1;
      m_tag = tag_of(op);
      m_phase = 0;
      case (op)
        4'h0: m_r[m_ir[7:6]] = a + b;
        4'h1: m_r[m_ir[7:6]] = a & b;
        4'h2: m_r[m_ir[7:6]] = a - b;
        4'h3: m_r[m_ir[7:6]] = ($signed(a) < $signed(b)) ? 16'd1 : 16'd0;
        4'h4: m_r[m_ir[7:6]] = ~a;
        4'h6: m_r[m_ir[7:6]] = a >> 1;
        4'h7: begin m_phase = 2; nxt = m_pc; end
        4'h8: m_r[m_ir[11:10]] = dmem[m_ea() & 16'hFF];
        4'hA: m_r[m_ir[11:10]] = m_ea();
        4'hD: nxt = m_ea();
        4'hE: if (a == 16'd0) nxt = m_ea();
        4'hF: begin nxt = m_ea(); m_r[m_ir[11:10]] = m_pc + 16'd1; end
        default: ;
      endcase
      m_pc = nxt;
    end
  endtask

  task automatic compare();
    logic [3:0] op;
    logic e_rd, e_wr, e_wb;
    op = m_ir[15:12];
    e_rd = (m_phase == 1) && (op == 4'h8);
    e_wr = (m_phase == 1) && (op == 4'h9);
    e_wb = (m_phase == 1) && (op inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h6, 4'h8, 4'hA, 4'hF});
    chk("R2", "instr_rd", 16'(instr_rd), 16'(m_phase == 0));
    if (m_phase == 0) chk(m_tag, "instr_addr", instr_addr, m_pc);
    chk(tag_of(op), "data_rd", 16'(data_rd), 16'(e_rd));
    chk(tag_of(op), "data_wr", 16'(data_wr), 16'(e_wr));
    if (e_rd || e_wr) chk(tag_of(op), "data_addr", data_addr, m_ea());
    if (e_wr) chk("R6", "data_wdata", data_wdata, m_r[m_ir[11:10]]);
    chk("R12", "wb_flag", 16'(wb_flag), 16'(e_wb));
    chk("R11", "halt_flag", 16'(halt_flag), 16'(m_phase == 2));
  endtask

  task automatic serve();
    if (instr_rd) instr_data = imem[instr_addr[5:0]];
    if (data_rd)  data_rdata = dmem[data_addr[7:0]];
    if (data_wr)  dmem[data_addr[7:0]] = data_wdata;
  endtask

  task automatic cycle();
    @(posedge clk); #1; model_step();
    @(negedge clk); #1; compare(); serve();
  endtask

  task automatic run_to_halt();
    int n = 0;
    while (m_phase != 2 && n < 400) begin cycle(); n++; end
    if (m_phase != 2) begin
      n_chk++; n_bad++;
      $display("FAIL R11 program did not halt: actual running expected halted");
    end
    for (int k = 0; k < 8; k++) cycle();
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog expired: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++)  imem[i] = 16'h7000;
    for (int i = 0; i < 256; i++) dmem[i] = 16'h1000 + 16'(i);
    dmem[4] = 16'hFFF0; dmem[5] = 16'h0007;
    imem[0]  = enc_d(9, 0, 0, 32);   imem[1]  = enc_d(9, 1, 0, 33);
    imem[2]  = enc_d(9, 2, 0, 34);   imem[3]  = enc_d(9, 3, 0, 35);
    imem[4]  = enc_d(8, 1, 0, 4);    imem[5]  = enc_d(8, 2, 0, 5);
    imem[6]  = enc_r(0, 1, 2, 3);    imem[7]  = enc_d(9, 3, 0, 64);
    imem[8]  = enc_r(1, 1, 2, 3);    imem[9]  = enc_d(9, 3, 0, 65);
    imem[10] = enc_r(2, 2, 1, 3);    imem[11] = enc_d(9, 3, 0, 66);
    imem[12] = enc_r(3, 1, 2, 3);    imem[13] = enc_d(9, 3, 0, 67);
    imem[14] = enc_r(3, 2, 1, 3);    imem[15] = enc_d(9, 3, 0, 68);
    imem[16] = enc_r(4, 1, 0, 3);    imem[17] = enc_d(9, 3, 0, 69);
    imem[18] = enc_r(6, 1, 0, 3);    imem[19] = enc_d(9, 3, 0, 70);
    imem[20] = enc_r(5, 1, 2, 3);    imem[21] = enc_d(11, 3, 0, 16);
    imem[22] = enc_d(12, 3, 1, 8);   imem[23] = enc_d(9, 3, 0, 71);
    imem[24] = enc_d(10, 3, 2, -3);  imem[25] = enc_d(9, 3, 3, -1);
    imem[26] = enc_d(14, 3, 0, 0);   imem[27] = enc_d(14, 0, 0, 29);
    imem[28] = enc_r(7, 0, 0, 0);    imem[29] = enc_d(15, 1, 0, 32);
    imem[30] = enc_d(9, 1, 0, 72);   imem[31] = enc_d(15, 2, 2, 26);
    imem[32] = enc_d(13, 0, 1, 0);   imem[33] = enc_d(9, 2, 0, 73);
    imem[34] = enc_d(10, 1, 0, -128); imem[35] = enc_d(9, 1, 0, 74);
    imem[36] = enc_d(10, 1, 1, 127); imem[37] = enc_d(9, 1, 0, 75);
    imem[38] = enc_r(0, 1, 1, 0);    imem[39] = enc_d(9, 0, 0, 8'h4E);
    imem[40] = enc_r(7, 0, 0, 0);

    instr_data = 16'h0; data_rdata = 16'h0;
    rst_n = 1'b0;
    for (int k = 0; k < 3; k++) cycle();
    rst_n = 1'b1;
    run_to_halt();

    chk("R3", "sum word", dmem[64], 16'hFFF7);
    chk("R3", "difference word", dmem[66], 16'h0017);
    chk("R4", "signed less word", dmem[67], 16'h0001);
    chk("R4", "shift word", dmem[70], 16'h7FF8);
    chk("R10", "word after no-ops", dmem[71], 16'h7FF8);
    chk("R6", "negative offset store", dmem[3], 16'h0004);
    chk("R8", "link after taken zero branch", dmem[72], 16'd30);
    chk("R9", "link equal to base", dmem[73], 16'd32);
    chk("R7", "offset -128", dmem[74], 16'hFF80);
    chk("R7", "offset +127", dmem[75], 16'hFFFF);
    chk("R5", "wrapped address store", dmem[76], 16'hFFFE);

    // Reset in the halted state, then rerun: registers must start from zero.
    for (int i = 32; i < 36; i++) dmem[i] = 16'hDEAD;
    rst_n = 1'b0;
    for (int k = 0; k < 2; k++) cycle();
    rst_n = 1'b1;
    run_to_halt();
    for (int i = 32; i < 36; i++) chk("R1", "cleared register", dmem[i], 16'h0000);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule